// File: doc/BRIEF.md
# Core Low-Power State Tracker

This block follows the power state of one processor core through four states: Normal, AutoHALT, Stop-Grant and Sleep. Each clock it samples a stop-clock request, a sleep request, a halt indication and a wake (bus or interrupt event) input. It moves between states only along legal paths, and it reports the state it has reached. A synchronous active-high reset returns it to Normal from any state. This includes Sleep, and the block does not step through Stop-Grant on the way.

Two enables follow from the state. One tells the snoop logic that it may service bus snoops, and the other tells the interrupt logic that it may latch interrupts. Both are held low for the whole time the core is in Sleep. The block also raises two one-cycle error flags. One marks a sleep request made outside Stop-Grant. The other marks any change on a watched input while the core sleeps. Clock gating, the snoop engine itself and the reset sequence belong to the blocks that consume these outputs.

Top module: `lpsPowerCtl`

## Requirements
- R1: The state encoding is Normal=2'b00, AutoHALT=2'b01, Stop-Grant=2'b10 and Sleep=2'b11. When `rst` is high at a clock edge, the next state is Normal and both error flags are low.
- R2: From Normal with `sleepReq` low, a high `stopClkReq` moves the block to Stop-Grant. Otherwise a high `haltInd` moves it to AutoHALT. Otherwise it stays in Normal.
- R3: From AutoHALT with `sleepReq` low, a high `stopClkReq` moves the block to Stop-Grant. Otherwise a high `wakeEvt` moves it to Normal. Otherwise it stays in AutoHALT.
- R4: From Stop-Grant, a high `sleepReq` moves the block to Sleep. Otherwise a low `stopClkReq` returns it to Normal. Otherwise it stays in Stop-Grant.
- R5: A high `sleepReq` while the state is Normal or AutoHALT (and `rst` is low) leaves the state unchanged and sets `sleepErr` high for the next cycle. Sleep is never entered from any state other than Stop-Grant.
- R6: `snoopEn` and `intLatchEn` are both low while the state is Sleep and both high in every other state, Normal, AutoHALT and Stop-Grant included.
- R7: From Sleep with `rst` low, a low `sleepReq` moves the block to Stop-Grant. A high `sleepReq` keeps it in Sleep, whatever the other inputs do.
- R8: With `rst` high while in Sleep, the next state is Normal. Stop-Grant is not visited.
- R9: While the state is Sleep and `rst` is low, a value of {`stopClkReq`,`haltInd`,`wakeEvt`} that differs from the value sampled one cycle earlier sets `protoErr` high for the next cycle.
- R10: Each error flag is high for exactly the cycle after its violating cycle and low in any cycle that follows a cycle with no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stopClkReq | input | 1 | Stop-clock request |
| sleepReq | input | 1 | Sleep request |
| haltInd | input | 1 | Core has executed a halt |
| wakeEvt | input | 1 | Interrupt or bus event that wakes a halted core |
| pwrState | output | 2 | Current state (encoding in R1) |
| snoopEn | output | 1 | Snoops may be serviced |
| intLatchEn | output | 1 | Interrupts may be latched |
| sleepErr | output | 1 | Sleep was requested outside Stop-Grant (one-cycle pulse) |
| protoErr | output | 1 | A watched input changed during Sleep (one-cycle pulse) |

## Verification
Every cycle, the assertions check several properties. Sleep is reached only from Stop-Grant. An illegal sleep request holds the state and flags `sleepErr`. Both enables are low exactly in Sleep. Reset always leads to Normal. Dropping the sleep request leaves Sleep for Stop-Grant. A watched-input change during Sleep is flagged. The bench covers what needs exact expected values: the priorities among simultaneous requests in each state, the full next-state table, and the return of the error flags to low. It applies all 32 combinations of the five inputs from each of the four states and compares every output against a model built from the requirements.

// File: rtl/lpsPkg.sv
package lpsPkg;
  localparam int STATE_W = 2;
  localparam int WATCH_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_NORMAL = 2'b00,
    PS_AHALT  = 2'b01,
    PS_STOPGR = 2'b10,
    PS_SLEEP  = 2'b11
  } pwrState_e;

  typedef struct packed {
    logic inSleep;
    logic sleepIllegal;
  } ctlStrobe_t;
endpackage

// File: rtl/lpsCtrl.sv
module lpsCtrl
  import lpsPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stopClkReq,
  input  logic       sleepReq,
  input  logic       haltInd,
  input  logic       wakeEvt,
  output pwrState_e  curState,
  output ctlStrobe_t strobe
);
  pwrState_e nextState;
  logic      badSleep;

  always_comb begin
    nextState = curState;
    badSleep  = 1'b0;
    unique case (curState)
      PS_NORMAL: begin
        if (sleepReq)        badSleep  = 1'b1;
        else if (stopClkReq) nextState = PS_STOPGR;
        else if (haltInd)    nextState = PS_AHALT;
      end
      PS_AHALT: begin
        if (sleepReq)        badSleep  = 1'b1;
        else if (stopClkReq) nextState = PS_STOPGR;
        else if (wakeEvt)    nextState = PS_NORMAL;
      end
      PS_STOPGR: begin
        if (sleepReq)         nextState = PS_SLEEP;
        else if (!stopClkReq) nextState = PS_NORMAL;
      end
      PS_SLEEP: begin
        if (!sleepReq) nextState = PS_STOPGR;
      end
      default: nextState = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= PS_NORMAL;
    else     curState <= nextState;
  end

  always_comb begin
    strobe.inSleep      = (curState == PS_SLEEP);
    strobe.sleepIllegal = badSleep & ~rst;
  end
endmodule

// File: rtl/lpsDatapath.sv
module lpsDatapath
  import lpsPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [WATCH_W-1:0] watched,
  input  ctlStrobe_t         strobe,
  output logic               snoopEn,
  output logic               intLatchEn,
  output logic               sleepErr,
  output logic               protoErr
);
  logic [WATCH_W-1:0] prevWatched;
  logic               watchMoved;

  assign watchMoved = |(watched ^ prevWatched);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevWatched <= '0;
      sleepErr    <= 1'b0;
      protoErr    <= 1'b0;
    end else begin
      prevWatched <= watched;
      sleepErr    <= strobe.sleepIllegal;
      protoErr    <= strobe.inSleep & watchMoved;
    end
  end

  assign snoopEn    = ~strobe.inSleep;
  assign intLatchEn = ~strobe.inSleep;
endmodule

// File: rtl/lpsPowerCtl.sv
module lpsPowerCtl
  import lpsPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         stopClkReq,
  input  logic         sleepReq,
  input  logic         haltInd,
  input  logic         wakeEvt,
  output logic [1:0]   pwrState,
  output logic         snoopEn,
  output logic         intLatchEn,
  output logic         sleepErr,
  output logic         protoErr
);
  pwrState_e  curState;
  ctlStrobe_t strobe;

  lpsCtrl u_ctrl (
    .clk(clk), .rst(rst), .stopClkReq(stopClkReq), .sleepReq(sleepReq),
    .haltInd(haltInd), .wakeEvt(wakeEvt), .curState(curState), .strobe(strobe)
  );

  lpsDatapath u_dp (
    .clk(clk), .rst(rst), .watched({stopClkReq, haltInd, wakeEvt}),
    .strobe(strobe), .snoopEn(snoopEn), .intLatchEn(intLatchEn),
    .sleepErr(sleepErr), .protoErr(protoErr)
  );

  assign pwrState = curState;
endmodule

// File: rtl/lpsPowerCtl_chk.sv
module lpsPowerCtl_chk (
  input logic       clk,
  input logic       rst,
  input logic       stopClkReq,
  input logic       sleepReq,
  input logic       haltInd,
  input logic       wakeEvt,
  input logic [1:0] pwrState,
  input logic       snoopEn,
  input logic       intLatchEn,
  input logic       sleepErr,
  input logic       protoErr
);
  logic seenEdge = 1'b0;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  a_r5_sleep_only_from_sg: assert property (@(posedge clk) disable iff (rst)
    (pwrState == 2'b00 || pwrState == 2'b01) |=> pwrState != 2'b11);

  a_r5_bad_sleep_flagged: assert property (@(posedge clk) disable iff (rst)
    (sleepReq && (pwrState == 2'b00 || pwrState == 2'b01)) |=> (sleepErr && $stable(pwrState)));

  a_r6_enables_off_in_sleep: assert property (@(posedge clk) disable iff (rst)
    (pwrState == 2'b11) |-> (!snoopEn && !intLatchEn));

  a_r6_enables_on_awake: assert property (@(posedge clk) disable iff (rst)
    (pwrState != 2'b11) |-> (snoopEn && intLatchEn));

  a_r8_reset_to_normal: assert property (@(posedge clk) disable iff (!seenEdge)
    rst |=> (pwrState == 2'b00 && !sleepErr && !protoErr));

  a_r7_wake_to_sg: assert property (@(posedge clk) disable iff (rst)
    (pwrState == 2'b11 && !sleepReq) |=> pwrState == 2'b10);

  a_r9_sleep_input_change: assert property (@(posedge clk) disable iff (rst)
    (pwrState == 2'b11 && ({stopClkReq, haltInd, wakeEvt} != $past({stopClkReq, haltInd, wakeEvt})))
      |=> protoErr);
endmodule

bind lpsPowerCtl lpsPowerCtl_chk u_chk (
  .clk(clk), .rst(rst), .stopClkReq(stopClkReq), .sleepReq(sleepReq),
  .haltInd(haltInd), .wakeEvt(wakeEvt), .pwrState(pwrState), .snoopEn(snoopEn),
  .intLatchEn(intLatchEn), .sleepErr(sleepErr), .protoErr(protoErr)
);

// File: tb/lpsPowerCtl_bench.sv
`timescale 1ns/1ps
module lpsPowerCtl_bench;
  logic clk = 1'b0;
  logic rst, stopClkReq, sleepReq, haltInd, wakeEvt;
  logic [1:0] pwrState;
  logic snoopEn, intLatchEn, sleepErr, protoErr;
  int nChecks = 0;
  int nErrors = 0;
  logic [2:0] prevW;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lpsPowerCtl u_lpsPowerCtl (
    .clk(clk), .rst(rst), .stopClkReq(stopClkReq), .sleepReq(sleepReq),
    .haltInd(haltInd), .wakeEvt(wakeEvt), .pwrState(pwrState), .snoopEn(snoopEn),
    .intLatchEn(intLatchEn), .sleepErr(sleepErr), .protoErr(protoErr)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at a negedge; return at the following negedge.
  task automatic drive(input logic r, input logic stp, input logic slp, input logic hlt, input logic wk);
    rst = r; stopClkReq = stp; sleepReq = slp; haltInd = hlt; wakeEvt = wk;
    @(negedge clk);
    prevW = {stp, hlt, wk};
  endtask

  // Reference next state and error flags, from R1-style table in the brief.
  function automatic logic [3:0] model(input logic [1:0] s, input logic r, input logic stp,
                                        input logic slp, input logic hlt, input logic wk,
                                        input logic [2:0] pw);
    logic [1:0] ns; logic se; logic pe;
    ns = s; se = 1'b0; pe = 1'b0;
    if (r) ns = 2'd0;
    else begin
      case (s)
        2'd0: if (slp) se = 1'b1; else if (stp) ns = 2'd2; else if (hlt) ns = 2'd1;
        2'd1: if (slp) se = 1'b1; else if (stp) ns = 2'd2; else if (wk) ns = 2'd0;
        2'd2: if (slp) ns = 2'd3; else if (!stp) ns = 2'd0;
        default: begin
          if (!slp) ns = 2'd2;
          pe = ({stp, hlt, wk} != pw);
        end
      endcase
    end
    return {ns, se, pe};
  endfunction

  task automatic gotoState(input logic [1:0] s);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    case (s)
      2'd1: drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      2'd2: drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      2'd3: begin
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      end
      default: ;
    endcase
  endtask

  initial begin
    #3000000;
    if (!done) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; stopClkReq = 1'b0; sleepReq = 1'b0; haltInd = 1'b0; wakeEvt = 1'b0;
    prevW = 3'b000;
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R1: reset state
    check("R1", "state after reset", pwrState, 0);
    check("R1", "sleepErr after reset", sleepErr, 0);
    check("R1", "protoErr after reset", protoErr, 0);
    check("R6", "snoopEn in Normal", snoopEn, 1);

    // Exhaustive sweep: every input combination from every state.
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 32; c++) begin
        logic [3:0] exp;
        logic [2:0] pw;
        string tagS;
        gotoState(s[1:0]);
        check("R1", "reached state", pwrState, s);
        check("R6", "snoopEn before", snoopEn, (s == 3) ? 0 : 1);
        check("R6", "intLatchEn before", intLatchEn, (s == 3) ? 0 : 1);
        pw = prevW;
        exp = model(s[1:0], c[4], c[3], c[2], c[1], c[0], pw);
        if (c[4]) tagS = (s == 3) ? "R8" : "R1";
        else if (s == 0) tagS = "R2";
        else if (s == 1) tagS = "R3";
        else if (s == 2) tagS = "R4";
        else tagS = "R7";
        drive(c[4], c[3], c[2], c[1], c[0]);
        check(tagS, "next state", pwrState, exp[3:2]);
        check("R5", "sleepErr", sleepErr, exp[1]);
        check("R9", "protoErr", protoErr, exp[0]);
        check("R6", "snoopEn after", snoopEn, (exp[3:2] == 2'd3) ? 0 : 1);
        check("R6", "intLatchEn after", intLatchEn, (exp[3:2] == 2'd3) ? 0 : 1);
      end
    end

    // R10: error pulses last one cycle.
    gotoState(2'd0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10", "sleepErr pulse", sleepErr, 1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10", "sleepErr cleared", sleepErr, 0);
    gotoState(2'd3);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R10", "protoErr pulse", protoErr, 1);
    check("R9", "state held in Sleep", pwrState, 3);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R10", "protoErr cleared", protoErr, 0);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7", "Sleep to Stop-Grant", pwrState, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule